// File: doc/BRIEF.md
# Dirty-Group Linked List Tracker

This block sits beside a set-associative mapping cache. It records which dirty cache blocks belong to the same translation page, so that a flush of one page can find all of its blocks without scanning the cache. A small table holds one entry per translation page that has dirty blocks. Each entry keeps the page number, a dirty-block count, registration and update ordering, and a head link. Each cache block owns a next-link register, so the dirty blocks of one page form a chain that starts at the entry's head link and ends at a reserved null link.

A "block became dirty" event carries the translation page and the set and way of the block. When a flush starts, the block picks a victim entry under one of three policies: greedy (most dirty blocks), oldest registered, or least recently updated. It removes that entry from the table and then streams the set:way of every chained block, one per cycle. A watermark controller watches the number of clean blocks. Once the clean count falls to the low watermark, it starts flushing on its own. It then alternates between a fixed burst of flushed blocks and a one-cycle slot for a new dirty event, until the clean count reaches the high watermark. Writing back the data is left to the surrounding logic.

Top module: `dirty_group_tracker`

## Requirements
- R1: After reset, walkValid is 0, dirtyReady is 1 and wmFlushing is 0. The table is empty, so a flush request emits nothing.
- R2: A dirty event for a clean block whose page has no entry, with a slot free, registers a new entry in the lowest free slot. The chain of that entry holds only this block. Traversing it gives that block alone, with walkLast high and walkPage equal to the page.
- R3: Each later dirty block of a page that already has an entry becomes the new head of that page's chain. A traversal therefore returns the page's blocks in reverse order of insertion.
- R4: A flush starts when flushReq is high, no traversal is running and at least one entry exists. From the next cycle, walkValid presents each chained block of the chosen page exactly once, one block per cycle, as set = index / NUM_WAYS and way = index % NUM_WAYS. No other block is presented. walkLast marks the block whose link is null. The entry is freed, so a second flush of that page emits nothing.
- R5: With flushMode = 1, the victim is the valid entry registered earliest, whatever slot it occupies.
- R6: A dirty event for a block that is already dirty changes neither the count nor the chain of its page.
- R7: With flushMode = 0 (and also with code 3), the victim is the entry with the most dirty blocks. On a tie, the lowest slot index wins.
- R8: With flushMode = 2, the victim is the entry whose most recent accepted new dirty block is the oldest.
- R9: When the clean-block count is at or below LOW_WM, wmFlushing rises and the block starts flushes by itself. While wmFlushing is high, dirtyReady is high only for single-cycle slots. Each slot follows exactly FLUSH_BURST emitted blocks, and no block is emitted in a slot. wmFlushing falls once the clean count reaches HIGH_WM. An event accepted in a slot is tracked normally.
- R10: A dirty event for a new page while all table slots are valid is dropped. That block never appears in any later traversal.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| dirtyValid | input | 1 | A block became dirty |
| dirtyPage | input | PAGE_W | Translation page of the block |
| dirtySet | input | SET_W | Set of the block |
| dirtyWay | input | WAY_W | Way of the block |
| dirtyReady | output | 1 | Event is taken on a clock edge where dirtyValid and dirtyReady are both high |
| flushReq | input | 1 | Start a flush of one page (taken when idle) |
| flushMode | input | 2 | Victim policy: 0 greedy, 1 oldest, 2 least recently updated, 3 greedy |
| walkValid | output | 1 | A traversed block is presented this cycle |
| walkSet | output | SET_W | Set of the traversed block |
| walkWay | output | WAY_W | Way of the traversed block |
| walkPage | output | PAGE_W | Page being flushed |
| walkLast | output | 1 | Presented block ends the chain |
| wmFlushing | output | 1 | Watermark-driven flushing is active |

## Verification
The in-line assertions check several properties on every cycle. The traversal cursor always points at a dirty block, and a presented block is clean one cycle later. Every valid entry counts at least one block. Exactly one entry holds the oldest registration rank and exactly one holds the oldest update rank. Under watermark pressure, a serve slot never lasts two cycles, and pressure is not released below the high watermark. Only the bench's scenarios can show the things that depend on history: the reverse insertion order of a chain, that duplicate events are ignored, which entry each policy selects, that events are dropped when the table is full, and the exact burst-then-serve pattern with a request held pending.

// File: rtl/dgl_pkg.sv
package dgl_pkg;

  typedef struct packed {
    logic acceptDirty;
    logic startWalk;
    logic stepWalk;
  } dgl_strobe_t;

  typedef enum logic [1:0] {
    FM_GREEDY = 2'd0,
    FM_OLDEST = 2'd1,
    FM_LRU    = 2'd2,
    FM_SPARE  = 2'd3
  } flush_mode_e;

endpackage

// File: rtl/dgl_datapath.sv
module dgl_datapath #(
  parameter int NUM_BLOCKS  = 8,
  parameter int NUM_ENTRIES = 4,
  parameter int PAGE_W      = 8,
  localparam int BI_W   = $clog2(NUM_BLOCKS),
  localparam int LINK_W = $clog2(NUM_BLOCKS + 1),
  localparam int CNT_W  = $clog2(NUM_BLOCKS + 1)
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  dgl_pkg::dgl_strobe_t     strobe,
  input  logic [PAGE_W-1:0]        dirtyPage,
  input  logic [BI_W-1:0]          dirtyIdx,
  input  logic [1:0]               flushMode,
  output logic                     walkActive,
  output logic                     anyValid,
  output logic [CNT_W-1:0]         cleanCount,
  output logic [BI_W-1:0]          walkIdx,
  output logic [PAGE_W-1:0]        walkPage,
  output logic                     walkLast
);
  import dgl_pkg::*;

  localparam int EI_W = (NUM_ENTRIES > 1) ? $clog2(NUM_ENTRIES) : 1;
  localparam logic [LINK_W-1:0] NULL_LINK = '1;

  // entry table
  logic              entValid [NUM_ENTRIES];
  logic [PAGE_W-1:0] entPage  [NUM_ENTRIES];
  logic [CNT_W-1:0]  entCnt   [NUM_ENTRIES];
  logic [LINK_W-1:0] entHead  [NUM_ENTRIES];
  logic [EI_W-1:0]   regRank  [NUM_ENTRIES];
  logic [EI_W-1:0]   updRank  [NUM_ENTRIES];

  // per-block state
  logic [NUM_BLOCKS-1:0] blkDirty;
  logic [LINK_W-1:0]     blkNext [NUM_BLOCKS];

  // traversal cursor
  logic [LINK_W-1:0] curLink;
  logic [PAGE_W-1:0] curPage;
  logic [BI_W-1:0]   curIdx;

  // lookup results
  logic            hitAny, freeAny;
  logic [EI_W-1:0] hitIdx, freeIdx;
  logic [EI_W:0]   validCnt;
  logic [EI_W-1:0] greedyIdx, oldIdx, lruIdx, victimIdx;
  logic [CNT_W-1:0] greedyCnt;
  logic            greedyHit;
  logic [NUM_ENTRIES-1:0] oldestVec, lruVec;
  logic            doAcc, doHit, doNew, doStep;
  logic [LINK_W-1:0] dirtyLink;

  assign curIdx     = BI_W'(curLink);
  assign walkActive = (curLink != NULL_LINK);
  assign walkIdx    = curIdx;
  assign walkPage   = curPage;
  assign walkLast   = (blkNext[curIdx] == NULL_LINK);
  assign anyValid   = (validCnt != '0);
  assign cleanCount = CNT_W'(NUM_BLOCKS) - CNT_W'($countones(blkDirty));
  assign dirtyLink  = LINK_W'(dirtyIdx);

  always_comb begin
    hitAny   = 1'b0;
    hitIdx   = '0;
    freeAny  = 1'b0;
    freeIdx  = '0;
    validCnt = '0;
    for (int i = 0; i < NUM_ENTRIES; i++) begin
      if (entValid[i] && entPage[i] == dirtyPage && !hitAny) begin
        hitAny = 1'b1;
        hitIdx = EI_W'(i);
      end
      if (!entValid[i] && !freeAny) begin
        freeAny = 1'b1;
        freeIdx = EI_W'(i);
      end
      validCnt = validCnt + (EI_W+1)'(entValid[i]);
    end
  end

  // victim choice for each policy
  always_comb begin
    greedyHit = 1'b0;
    greedyIdx = '0;
    greedyCnt = '0;
    oldIdx    = '0;
    lruIdx    = '0;
    oldestVec = '0;
    lruVec    = '0;
    for (int i = 0; i < NUM_ENTRIES; i++) begin
      if (entValid[i]) begin
        if (!greedyHit || entCnt[i] > greedyCnt) begin
          greedyHit = 1'b1;
          greedyIdx = EI_W'(i);
          greedyCnt = entCnt[i];
        end
        if (regRank[i] == '0) begin
          oldIdx       = EI_W'(i);
          oldestVec[i] = 1'b1;
        end
        if (updRank[i] == '0) begin
          lruIdx    = EI_W'(i);
          lruVec[i] = 1'b1;
        end
      end
    end
    case (flush_mode_e'(flushMode))
      FM_OLDEST: victimIdx = oldIdx;
      FM_LRU:    victimIdx = lruIdx;
      default:   victimIdx = greedyIdx;
    endcase
  end

  assign doAcc  = strobe.acceptDirty && !blkDirty[dirtyIdx];
  assign doHit  = doAcc && hitAny;
  assign doNew  = doAcc && !hitAny && freeAny;
  assign doStep = strobe.stepWalk && walkActive;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      blkDirty <= '0;
      curLink  <= NULL_LINK;
      curPage  <= '0;
      for (int b = 0; b < NUM_BLOCKS; b++) blkNext[b] <= NULL_LINK;
      for (int i = 0; i < NUM_ENTRIES; i++) begin
        entValid[i] <= 1'b0;
        entPage[i]  <= '0;
        entCnt[i]   <= '0;
        entHead[i]  <= NULL_LINK;
        regRank[i]  <= '0;
        updRank[i]  <= '0;
      end
    end else begin
      if (doHit) begin
        // head insertion: old head moves into the block's own link
        blkNext[dirtyIdx] <= entHead[hitIdx];
        entHead[hitIdx]   <= dirtyLink;
        entCnt[hitIdx]    <= entCnt[hitIdx] + 1'b1;
        blkDirty[dirtyIdx] <= 1'b1;
        for (int i = 0; i < NUM_ENTRIES; i++) begin
          if (entValid[i] && updRank[i] > updRank[hitIdx])
            updRank[i] <= updRank[i] - 1'b1;
        end
        updRank[hitIdx] <= EI_W'(validCnt - 1'b1);
      end
      if (doNew) begin
        entValid[freeIdx] <= 1'b1;
        entPage[freeIdx]  <= dirtyPage;
        entCnt[freeIdx]   <= CNT_W'(1);
        entHead[freeIdx]  <= dirtyLink;
        regRank[freeIdx]  <= EI_W'(validCnt);
        updRank[freeIdx]  <= EI_W'(validCnt);
        blkNext[dirtyIdx] <= NULL_LINK;
        blkDirty[dirtyIdx] <= 1'b1;
      end
      if (strobe.startWalk) begin
        // detach the victim so later events on its page open a fresh entry
        entValid[victimIdx] <= 1'b0;
        entCnt[victimIdx]   <= '0;
        curLink <= entHead[victimIdx];
        curPage <= entPage[victimIdx];
        for (int i = 0; i < NUM_ENTRIES; i++) begin
          if (entValid[i] && EI_W'(i) != victimIdx) begin
            if (regRank[i] > regRank[victimIdx]) regRank[i] <= regRank[i] - 1'b1;
            if (updRank[i] > updRank[victimIdx]) updRank[i] <= updRank[i] - 1'b1;
          end
        end
      end
      if (doStep) begin
        blkDirty[curIdx] <= 1'b0;
        blkNext[curIdx]  <= NULL_LINK;
        curLink          <= blkNext[curIdx];
      end
    end
  end

  AST_WALK_DIRTY: assert property (@(posedge clk) disable iff (!rst_n)
    walkActive |-> blkDirty[curIdx]); // R4

  AST_STEP_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
    doStep |=> !blkDirty[$past(curIdx)]); // R4

  AST_SINGLE_OLDEST: assert property (@(posedge clk) disable iff (!rst_n)
    anyValid |-> $countones(oldestVec) == 1); // R5

  AST_SINGLE_LRU: assert property (@(posedge clk) disable iff (!rst_n)
    anyValid |-> $countones(lruVec) == 1); // R8

  for (genvar g = 0; g < NUM_ENTRIES; g++) begin : gEntChk
    AST_ENTRY_NONEMPTY: assert property (@(posedge clk) disable iff (!rst_n)
      entValid[g] |-> entCnt[g] != '0); // R2
  end

endmodule

// File: rtl/dgl_control.sv
module dgl_control #(
  parameter int CNT_W       = 4,
  parameter int LOW_WM      = 2,
  parameter int HIGH_WM     = 5,
  parameter int FLUSH_BURST = 2,
  localparam int BC_W = $clog2(FLUSH_BURST + 1)
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 dirtyValid,
  input  logic                 flushReq,
  input  logic                 walkActive,
  input  logic                 anyValid,
  input  logic [CNT_W-1:0]     cleanCount,
  output dgl_pkg::dgl_strobe_t strobe,
  output logic                 dirtyReady,
  output logic                 wmFlushing
);

  localparam logic [CNT_W-1:0] LOW_C   = CNT_W'(LOW_WM);
  localparam logic [CNT_W-1:0] HIGH_C  = CNT_W'(HIGH_WM);
  localparam logic [BC_W-1:0]  BURST_E = BC_W'(FLUSH_BURST - 1);

  logic            pressure;
  logic            serve;
  logic [BC_W-1:0] burstCnt;

  assign wmFlushing = pressure;

  always_comb begin
    strobe.startWalk   = !walkActive && anyValid && (flushReq || (pressure && !serve));
    strobe.stepWalk    = walkActive && !(pressure && serve);
    dirtyReady         = (!pressure || serve) && !strobe.startWalk;
    strobe.acceptDirty = dirtyValid && dirtyReady;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pressure <= 1'b0;
      serve    <= 1'b0;
      burstCnt <= '0;
    end else begin
      if (!pressure && cleanCount <= LOW_C)
        pressure <= 1'b1;
      else if (pressure && cleanCount >= HIGH_C)
        pressure <= 1'b0;

      if (!pressure) begin
        serve    <= 1'b0;
        burstCnt <= '0;
      end else if (serve) begin
        serve <= 1'b0;
      end else if (strobe.stepWalk) begin
        if (burstCnt == BURST_E) begin
          serve    <= 1'b1;
          burstCnt <= '0;
        end else begin
          burstCnt <= burstCnt + 1'b1;
        end
      end
    end
  end

  AST_SERVE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    (pressure && dirtyReady) |=> !(pressure && dirtyReady)); // R9

  AST_HYST_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (pressure && cleanCount < HIGH_C) |=> pressure); // R9

endmodule

// File: rtl/dirty_group_tracker.sv
module dirty_group_tracker #(
  parameter int NUM_SETS    = 4,
  parameter int NUM_WAYS    = 2,
  parameter int NUM_ENTRIES = 4,
  parameter int PAGE_W      = 8,
  parameter int LOW_WM      = 2,
  parameter int HIGH_WM     = 5,
  parameter int FLUSH_BURST = 2,
  localparam int SET_W = $clog2(NUM_SETS),
  localparam int WAY_W = $clog2(NUM_WAYS)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              dirtyValid,
  input  logic [PAGE_W-1:0] dirtyPage,
  input  logic [SET_W-1:0]  dirtySet,
  input  logic [WAY_W-1:0]  dirtyWay,
  output logic              dirtyReady,
  input  logic              flushReq,
  input  logic [1:0]        flushMode,
  output logic              walkValid,
  output logic [SET_W-1:0]  walkSet,
  output logic [WAY_W-1:0]  walkWay,
  output logic [PAGE_W-1:0] walkPage,
  output logic              walkLast,
  output logic              wmFlushing
);

  localparam int NB    = NUM_SETS * NUM_WAYS;
  localparam int BI_W  = $clog2(NB);
  localparam int CNT_W = $clog2(NB + 1);

  dgl_pkg::dgl_strobe_t strobe;
  logic             walkActive, anyValid;
  logic [CNT_W-1:0] cleanCount;
  logic [BI_W-1:0]  dirtyIdx, walkIdx;

  assign dirtyIdx  = BI_W'(int'(dirtySet) * NUM_WAYS + int'(dirtyWay));
  assign walkSet   = SET_W'(int'(walkIdx) / NUM_WAYS);
  assign walkWay   = WAY_W'(int'(walkIdx) % NUM_WAYS);
  assign walkValid = strobe.stepWalk;

  dgl_datapath #(
    .NUM_BLOCKS (NB),
    .NUM_ENTRIES(NUM_ENTRIES),
    .PAGE_W     (PAGE_W)
  ) u_dp (
    .clk       (clk),
    .rst_n     (rst_n),
    .strobe    (strobe),
    .dirtyPage (dirtyPage),
    .dirtyIdx  (dirtyIdx),
    .flushMode (flushMode),
    .walkActive(walkActive),
    .anyValid  (anyValid),
    .cleanCount(cleanCount),
    .walkIdx   (walkIdx),
    .walkPage  (walkPage),
    .walkLast  (walkLast)
  );

  dgl_control #(
    .CNT_W      (CNT_W),
    .LOW_WM     (LOW_WM),
    .HIGH_WM    (HIGH_WM),
    .FLUSH_BURST(FLUSH_BURST)
  ) u_ctl (
    .clk       (clk),
    .rst_n     (rst_n),
    .dirtyValid(dirtyValid),
    .flushReq  (flushReq),
    .walkActive(walkActive),
    .anyValid  (anyValid),
    .cleanCount(cleanCount),
    .strobe    (strobe),
    .dirtyReady(dirtyReady),
    .wmFlushing(wmFlushing)
  );

endmodule

// File: tb/dirty_group_tracker_tb.sv
`timescale 1ns/1ps
module dirty_group_tracker_tb;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       dirtyValid = 1'b0;
  logic [7:0] dirtyPage = '0;
  logic [1:0] dirtySet = '0;
  logic [0:0] dirtyWay = '0;
  logic       dirtyReady;
  logic       flushReq = 1'b0;
  logic [1:0] flushMode = '0;
  logic       walkValid;
  logic [1:0] walkSet;
  logic [0:0] walkWay;
  logic [7:0] walkPage;
  logic       walkLast;
  logic       wmFlushing;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  int gotIdx[16];
  int gotPage[16];
  int gotN;
  int lastAt;

  always #2.5 clk = ~clk;

  dirty_group_tracker u_dut (
    .clk(clk), .rst_n(rst_n),
    .dirtyValid(dirtyValid), .dirtyPage(dirtyPage), .dirtySet(dirtySet),
    .dirtyWay(dirtyWay), .dirtyReady(dirtyReady),
    .flushReq(flushReq), .flushMode(flushMode),
    .walkValid(walkValid), .walkSet(walkSet), .walkWay(walkWay),
    .walkPage(walkPage), .walkLast(walkLast), .wmFlushing(wmFlushing)
  );

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic sendDirty(input int page, input int idx);
    @(negedge clk);
    dirtyValid = 1'b1;
    dirtyPage  = 8'(page);
    dirtySet   = 2'(idx / 2);
    dirtyWay   = 1'(idx % 2);
    for (int k = 0; k < 50 && !dirtyReady; k++) @(negedge clk);
    @(posedge clk);
    @(negedge clk);
    dirtyValid = 1'b0;
  endtask

  task automatic flushCollect(input int mode);
    gotN = 0;
    lastAt = -1;
    @(negedge clk);
    flushReq  = 1'b1;
    flushMode = 2'(mode);
    @(posedge clk);
    @(negedge clk);
    flushReq = 1'b0;
    for (int k = 0; k < 20; k++) begin
      if (walkValid) begin
        gotIdx[gotN]  = int'(walkSet) * 2 + int'(walkWay);
        gotPage[gotN] = int'(walkPage);
        if (walkLast && lastAt < 0) lastAt = gotN;
        gotN++;
        if (walkLast) break;
      end
      @(negedge clk);
    end
  endtask

  task automatic expectSeq(input string tag, input int page, input int n,
                           input int e0, input int e1, input int e2);
    int exp[3];
    exp[0] = e0; exp[1] = e1; exp[2] = e2;
    check(gotN == n, {tag, " length"}, gotN, n);
    for (int k = 0; k < n && k < gotN; k++) begin
      check(gotIdx[k] == exp[k], {tag, " block"}, gotIdx[k], exp[k]);
      check(gotPage[k] == page, {tag, " page"}, gotPage[k], page);
    end
    if (n > 0) check(lastAt == n - 1, {tag, " last"}, lastAt, n - 1);
  endtask

  task automatic t_reset();
    @(negedge clk);
    check(walkValid == 1'b0, "R1 walkValid", int'(walkValid), 0);
    check(dirtyReady == 1'b1, "R1 dirtyReady", int'(dirtyReady), 1);
    check(wmFlushing == 1'b0, "R1 wmFlushing", int'(wmFlushing), 0);
    flushCollect(0);
    check(gotN == 0, "R1 empty flush", gotN, 0);
  endtask

  task automatic t_chain();
    sendDirty(8'h11, 3);
    flushCollect(1);
    expectSeq("R2 single", 8'h11, 1, 3, 0, 0);
    sendDirty(8'h11, 3);
    sendDirty(8'h11, 5);
    sendDirty(8'h11, 1);
    flushCollect(1);
    expectSeq("R3 reverse order", 8'h11, 3, 1, 5, 3);
  endtask

  task automatic t_dup();
    sendDirty(8'h22, 2);
    sendDirty(8'h22, 2);
    sendDirty(8'h22, 6);
    flushCollect(1);
    expectSeq("R6 duplicate ignored", 8'h22, 2, 6, 2, 0);
    flushCollect(1);
    check(gotN == 0, "R4 entry freed", gotN, 0);
  endtask

  task automatic t_greedy();
    sendDirty(8'h30, 0);
    sendDirty(8'h30, 0);
    sendDirty(8'h30, 0);
    sendDirty(8'h31, 1);
    sendDirty(8'h31, 2);
    sendDirty(8'h32, 3);
    sendDirty(8'h32, 4);
    flushCollect(0);
    expectSeq("R7 greedy tie lowest slot, R6 count", 8'h31, 2, 2, 1, 0);
    flushCollect(0);
    expectSeq("R7 greedy second", 8'h32, 2, 4, 3, 0);
    flushCollect(3);
    expectSeq("R7 code 3 greedy", 8'h30, 1, 0, 0, 0);
  endtask

  task automatic t_oldest();
    sendDirty(8'h40, 0);
    sendDirty(8'h41, 1);
    sendDirty(8'h41, 2);
    sendDirty(8'h42, 3);
    flushCollect(0);
    expectSeq("R7 greedy pick", 8'h41, 2, 2, 1, 0);
    sendDirty(8'h43, 4);
    flushCollect(1);
    expectSeq("R5 oldest first", 8'h40, 1, 0, 0, 0);
    flushCollect(1);
    expectSeq("R5 oldest second", 8'h42, 1, 3, 0, 0);
    flushCollect(1);
    expectSeq("R5 newest last", 8'h43, 1, 4, 0, 0);
  endtask

  task automatic t_lru();
    sendDirty(8'h50, 0);
    sendDirty(8'h51, 1);
    sendDirty(8'h52, 2);
    sendDirty(8'h50, 3);
    flushCollect(2);
    expectSeq("R8 lru first", 8'h51, 1, 1, 0, 0);
    flushCollect(2);
    expectSeq("R8 lru second", 8'h52, 1, 2, 0, 0);
    flushCollect(2);
    expectSeq("R8 lru touched last", 8'h50, 2, 3, 0, 0);
  endtask

  task automatic t_full();
    sendDirty(8'h60, 0);
    sendDirty(8'h61, 1);
    sendDirty(8'h62, 2);
    sendDirty(8'h63, 3);
    sendDirty(8'h64, 4);
    sendDirty(8'h61, 5);
    flushCollect(1);
    expectSeq("R10 slot0", 8'h60, 1, 0, 0, 0);
    flushCollect(1);
    expectSeq("R10 hit while full", 8'h61, 2, 5, 1, 0);
    flushCollect(1);
    expectSeq("R10 slot2", 8'h62, 1, 2, 0, 0);
    flushCollect(1);
    expectSeq("R10 slot3", 8'h63, 1, 3, 0, 0);
    flushCollect(1);
    check(gotN == 0, "R10 dropped block never walked", gotN, 0);
  endtask

  task automatic t_pressure();
    int sinceServe;
    int serves;
    bit accepted;
    bit clearNext;
    bit sawLast;
    int k;
    for (int b = 0; b < 6; b++) sendDirty(8'h70, b);
    k = 0;
    while (!wmFlushing && k < 10) begin
      @(negedge clk);
      k++;
    end
    check(wmFlushing == 1'b1, "R9 pressure rises", int'(wmFlushing), 1);
    check(dirtyReady == 1'b0, "R9 not ready in flush phase", int'(dirtyReady), 0);
    dirtyValid = 1'b1;
    dirtyPage  = 8'h71;
    dirtySet   = 2'd3;
    dirtyWay   = 1'b1;
    gotN = 0;
    sinceServe = 0;
    serves = 0;
    accepted = 1'b0;
    clearNext = 1'b0;
    sawLast = 1'b0;
    for (int c = 0; c < 60; c++) begin
      if (clearNext) begin
        dirtyValid = 1'b0;
        clearNext = 1'b0;
      end
      if (wmFlushing && dirtyReady) begin
        check(sinceServe == 2, "R9 burst before serve", sinceServe, 2);
        check(walkValid == 1'b0, "R9 no emit in serve", int'(walkValid), 0);
        sinceServe = 0;
        serves++;
      end
      if (dirtyValid && dirtyReady) begin
        accepted = 1'b1;
        clearNext = 1'b1;
      end
      if (walkValid) begin
        if (gotN < 16) begin
          gotIdx[gotN]  = int'(walkSet) * 2 + int'(walkWay);
          gotPage[gotN] = int'(walkPage);
        end
        gotN++;
        if (wmFlushing) sinceServe++;
        if (walkLast) sawLast = 1'b1;
      end
      if (sawLast && !wmFlushing) break;
      @(negedge clk);
    end
    dirtyValid = 1'b0;
    check(serves >= 1, "R9 serve slots seen", serves, 1);
    check(accepted == 1'b1, "R9 request served", int'(accepted), 1);
    check(gotN == 6, "R9 flushed count", gotN, 6);
    for (int j = 0; j < 6 && j < gotN; j++)
      check(gotIdx[j] == 5 - j, "R9 flushed order", gotIdx[j], 5 - j);
    @(negedge clk);
    check(wmFlushing == 1'b0, "R9 pressure released", int'(wmFlushing), 0);
    check(dirtyReady == 1'b1, "R9 ready after release", int'(dirtyReady), 1);
    flushCollect(1);
    expectSeq("R9 served event tracked", 8'h71, 1, 7, 0, 0);
  endtask

  initial begin
    repeat (4) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    t_reset();
    t_chain();
    t_dup();
    t_greedy();
    t_oldest();
    t_lru();
    t_full();
    t_pressure();
    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

endmodule